// File: doc/BRIEF.md
# Physical Register Ready Scoreboard

This block holds one ready bit for every physical register of an out-of-order core. The index into the bit array is flat and covers one register space shared by all register classes. Rename allocation uses the clear port to mark a newly allocated destination as not ready. Writeback uses the set port to mark a produced register as ready. Issue logic reads operand readiness through a parameterised number of lookup ports, two by default.

Every request carries a flat index and two attribute flags. The first flag, "pinned", marks a register with a permanent mapping. Such a register always reads as ready and cannot be changed. The second flag, "hardwired zero", marks the zero register. A clear aimed at it is dropped, so it never leaves the ready state. An index at or above the register count is illegal, and so is a zero-register lookup that finds its bit not ready. Either case latches a sticky error output that only reset removes.

Lookups are combinational. They see the array as it stood before the current cycle's set and clear take effect, and there is no bypass. If a set and a clear target the same index in the same cycle, the clear wins.

Top module: `preg_ready_board`

## Requirements
- R1: After synchronous reset every ready bit is 1 and the error output is 0.
- R2: A set marks its register ready and a clear marks it not ready. Either change is visible to lookups from the cycle after the request.
- R3: A lookup of a pinned register returns 1 whatever the stored bit holds, including an index that is out of range.
- R4: A set or clear carrying the pinned flag leaves the array unchanged.
- R5: A clear carrying the hardwired-zero flag (without pinned) leaves the array unchanged.
- R6: When set and clear name the same index in one cycle, the bit ends not ready.
- R7: Lookups are combinational with no bypass: a lookup in the same cycle as a set or clear of its index returns the old value.
- R8: An enabled request whose index is not below NUM_REGS raises the error output one cycle later. Such a set or clear changes nothing, and such an unpinned lookup returns 0.
- R9: A non-pinned lookup with the hardwired-zero flag that finds its bit at 0 returns 0 and raises the error output one cycle later.
- R10: Once raised, the error output stays 1 until reset, whatever requests follow.
- R11: The lookup ports are independent: each returns the state of its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | RD_PORTS | Lookup enable, one bit per port |
| lk_idx | input | RD_PORTS*IDX_W | Lookup indices, port p at bits [p*IDX_W +: IDX_W] |
| lk_pinned | input | RD_PORTS | Lookup pinned flag per port |
| lk_zero | input | RD_PORTS | Lookup hardwired-zero flag per port |
| lk_ready | output | RD_PORTS | Combinational readiness per port |
| set_en | input | 1 | Writeback set request |
| set_idx | input | IDX_W | Set index |
| set_pinned | input | 1 | Set pinned flag |
| set_zero | input | 1 | Set hardwired-zero flag |
| clr_en | input | 1 | Allocation clear request |
| clr_idx | input | IDX_W | Clear index |
| clr_pinned | input | 1 | Clear pinned flag |
| clr_zero | input | 1 | Clear hardwired-zero flag |
| err | output | 1 | Sticky error flag |

## Verification
A set and a clear can land in the same cycle on the same index, and a lookup can read that index in that cycle too. The bench drives all three together at identical and at distinct indices. It checks that the lookup returns the pre-update bit and that the bit reads not ready one cycle later. Random set, clear and lookup traffic, including pinned flags, runs against a reference bit array that applies the clear-wins rule. Every lookup result is compared with that array.

// File: rtl/prrb_pkg.sv
package prrb_pkg;
  typedef struct packed {
    logic en;
    logic pinned;
    logic zero;
  } req_attr_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prrb_req_gate.sv
module prrb_req_gate
  import prrb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter bit IS_CLEAR = 1'b0,
  localparam int IDX_W = idx_width(NUM_REGS)
) (
  input  req_attr_t        attr,
  input  logic [IDX_W-1:0] idx,
  output logic             we,
  output logic             oor
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);
  logic in_range;
  logic blocked;

  assign in_range = {1'b0, idx} < LIMIT;
  assign oor      = attr.en && !in_range;

  generate
    if (IS_CLEAR) begin : g_clr
      assign blocked = attr.pinned || attr.zero;
    end else begin : g_set
      assign blocked = attr.pinned;
    end
  endgenerate

  assign we = attr.en && in_range && !blocked;
endmodule

// File: rtl/prrb_ready_array.sv
module prrb_ready_array
  import prrb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int IDX_W = idx_width(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_we,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                clr_we,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] bits
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)                                     bits[gi] <= 1'b1;
        else if (clr_we && clr_idx == IDX_W'(gi))    bits[gi] <= 1'b0;
        else if (set_we && set_idx == IDX_W'(gi))    bits[gi] <= 1'b1;
      end
    end
  endgenerate

  // R6: simultaneous set and clear of one index leaves it not ready
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_we && clr_we && set_idx == clr_idx) |=> !bits[$past(clr_idx)]);

  // R2: a lone set makes its bit ready next cycle
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (set_we && !(clr_we && clr_idx == set_idx)) |=> bits[$past(set_idx)]);

  // R2: a clear makes its bit not ready next cycle
  assert_clear_lands_R2: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> !bits[$past(clr_idx)]);
endmodule

// File: rtl/prrb_lookup.sv
module prrb_lookup
  import prrb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int IDX_W = idx_width(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] bits,
  input  req_attr_t           attr,
  input  logic [IDX_W-1:0]    idx,
  output logic                ready,
  output logic                oor,
  output logic                zero_fault
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);
  logic in_range;
  logic stored;

  assign in_range = {1'b0, idx} < LIMIT;

  always_comb begin
    stored = 1'b0;
    for (int k = 0; k < NUM_REGS; k++)
      if (idx == IDX_W'(k)) stored = bits[k];
  end

  always_comb begin
    if (attr.pinned)   ready = 1'b1;
    else if (in_range) ready = stored;
    else               ready = 1'b0;
  end

  assign oor        = attr.en && !in_range;
  assign zero_fault = attr.en && in_range && !attr.pinned && attr.zero && !stored;
endmodule

// File: rtl/prrb_err_latch.sv
module prrb_err_latch #(
  parameter int SRCS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SRCS-1:0] fault,
  output logic            err
);
  always_ff @(posedge clk) begin
    if (rst)        err <= 1'b0;
    else if (|fault) err <= 1'b1;
  end

  // R10: error is sticky until reset
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R8, R9: any fault raises the flag next cycle
  assert_fault_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (|fault) |=> err);
endmodule

// File: rtl/preg_ready_board.sv
module preg_ready_board
  import prrb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int RD_PORTS = 2,
  localparam int IDX_W = idx_width(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [RD_PORTS-1:0]       lk_en,
  input  logic [RD_PORTS*IDX_W-1:0] lk_idx,
  input  logic [RD_PORTS-1:0]       lk_pinned,
  input  logic [RD_PORTS-1:0]       lk_zero,
  output logic [RD_PORTS-1:0]       lk_ready,
  input  logic                      set_en,
  input  logic [IDX_W-1:0]          set_idx,
  input  logic                      set_pinned,
  input  logic                      set_zero,
  input  logic                      clr_en,
  input  logic [IDX_W-1:0]          clr_idx,
  input  logic                      clr_pinned,
  input  logic                      clr_zero,
  output logic                      err
);
  localparam int FAULTS = 2 + 2 * RD_PORTS;

  logic [NUM_REGS-1:0] ready_vec;
  logic                set_we, clr_we, set_oor, clr_oor;
  logic [RD_PORTS-1:0] lk_oor, lk_zf;
  req_attr_t           set_attr, clr_attr;

  assign set_attr = '{en: set_en, pinned: set_pinned, zero: set_zero};
  assign clr_attr = '{en: clr_en, pinned: clr_pinned, zero: clr_zero};

  prrb_req_gate #(.NUM_REGS(NUM_REGS), .IS_CLEAR(1'b0)) u_set_gate (
    .attr(set_attr), .idx(set_idx), .we(set_we), .oor(set_oor));

  prrb_req_gate #(.NUM_REGS(NUM_REGS), .IS_CLEAR(1'b1)) u_clr_gate (
    .attr(clr_attr), .idx(clr_idx), .we(clr_we), .oor(clr_oor));

  prrb_ready_array #(.NUM_REGS(NUM_REGS)) u_array (
    .clk(clk), .rst(rst),
    .set_we(set_we), .set_idx(set_idx),
    .clr_we(clr_we), .clr_idx(clr_idx),
    .bits(ready_vec));

  genvar gp;
  generate
    for (gp = 0; gp < RD_PORTS; gp++) begin : g_port
      req_attr_t la;
      assign la = '{en: lk_en[gp], pinned: lk_pinned[gp], zero: lk_zero[gp]};
      prrb_lookup #(.NUM_REGS(NUM_REGS)) u_lookup (
        .bits(ready_vec), .attr(la),
        .idx(lk_idx[gp*IDX_W +: IDX_W]),
        .ready(lk_ready[gp]), .oor(lk_oor[gp]), .zero_fault(lk_zf[gp]));

      // R3: pinned lookups always read ready
      assert_pinned_reads_ready_R3: assert property (@(posedge clk) disable iff (rst)
        lk_pinned[gp] |-> lk_ready[gp]);
    end
  endgenerate

  prrb_err_latch #(.SRCS(FAULTS)) u_err (
    .clk(clk), .rst(rst),
    .fault({lk_zf, lk_oor, clr_oor, set_oor}),
    .err(err));

  // R4: pinned set with no effective clear leaves the array untouched
  assert_pinned_set_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_pinned && !clr_we) |=> $stable(ready_vec));

  // R5: zero-register clear with no effective set leaves the array untouched
  assert_zero_clear_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_zero && !set_we) |=> $stable(ready_vec));

  // R8: out-of-range set with no clear has no effect
  assert_oor_set_inert_R8: assert property (@(posedge clk) disable iff (rst)
    (set_oor && !clr_we) |=> $stable(ready_vec));
endmodule

// File: tb/preg_ready_board_bench.sv
`timescale 1ns/1ps
module preg_ready_board_bench;
  localparam int N  = 96;
  localparam int RP = 2;
  localparam int W  = 7;

  logic clk = 1'b0;
  logic rst;
  logic [RP-1:0]   lk_en, lk_pinned, lk_zero, lk_ready;
  logic [RP*W-1:0] lk_idx;
  logic set_en, set_pinned, set_zero, clr_en, clr_pinned, clr_zero, err;
  logic [W-1:0] set_idx, clr_idx;

  int n_chk = 0, n_bad = 0;
  bit ref_bits [N];
  bit done = 1'b0;

  always #4 clk = ~clk;

  preg_ready_board #(.NUM_REGS(N), .RD_PORTS(RP)) u_preg_ready_board (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_idx(lk_idx),
    .lk_pinned(lk_pinned), .lk_zero(lk_zero), .lk_ready(lk_ready),
    .set_en(set_en), .set_idx(set_idx), .set_pinned(set_pinned), .set_zero(set_zero),
    .clr_en(clr_en), .clr_idx(clr_idx), .clr_pinned(clr_pinned), .clr_zero(clr_zero),
    .err(err));

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_en = '0; lk_pinned = '0; lk_zero = '0; lk_idx = '0;
    set_en = 0; set_idx = '0; set_pinned = 0; set_zero = 0;
    clr_en = 0; clr_idx = '0; clr_pinned = 0; clr_zero = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic look(input int p, input int idx, input bit pin, input bit zf);
    lk_en[p] = 1'b1; lk_idx[p*W +: W] = W'(idx); lk_pinned[p] = pin; lk_zero[p] = zf;
    #1;
  endtask

  task automatic do_reset();
    idle(); rst = 1'b1; step(); step(); rst = 1'b0;
    foreach (ref_bits[i]) ref_bits[i] = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check(err, 1'b0, "R1", "err after reset");
    for (int i = 0; i < N; i++) begin
      look(0, i, 0, 0);
      check(lk_ready[0], 1'b1, "R1", $sformatf("bit %0d after reset", i));
    end
    idle();
  endtask

  task automatic t_set_clear_bypass();
    clr_en = 1; clr_idx = 7'd20; look(0, 20, 0, 0);
    check(lk_ready[0], 1'b1, "R7", "lookup during clear sees old");
    step(); idle(); look(0, 20, 0, 0);
    check(lk_ready[0], 1'b0, "R2", "cleared reg not ready");
    set_en = 1; set_idx = 7'd20; #1;
    check(lk_ready[0], 1'b0, "R7", "lookup during set sees old");
    step(); idle(); look(0, 20, 0, 0);
    check(lk_ready[0], 1'b1, "R2", "set reg ready");
    idle();
  endtask

  task automatic t_pinned();
    clr_en = 1; clr_idx = 7'd30; step(); idle();
    look(0, 30, 1, 0);
    check(lk_ready[0], 1'b1, "R3", "pinned lookup of cleared reg");
    idle(); set_en = 1; set_idx = 7'd30; set_pinned = 1; step(); idle();
    look(0, 30, 0, 0);
    check(lk_ready[0], 1'b0, "R4", "pinned set ignored");
    idle(); clr_en = 1; clr_idx = 7'd31; clr_pinned = 1; step(); idle();
    look(0, 31, 0, 0);
    check(lk_ready[0], 1'b1, "R4", "pinned clear ignored");
    idle(); set_en = 1; set_idx = 7'd30; step(); idle();
  endtask

  task automatic t_zero_clear();
    clr_en = 1; clr_idx = 7'd0; clr_zero = 1; step(); idle();
    look(0, 0, 0, 1);
    check(lk_ready[0], 1'b1, "R5", "zero reg clear ignored");
    step();
    check(err, 1'b0, "R5", "no error on zero reg");
    idle();
  endtask

  task automatic t_collision();
    set_en = 1; set_idx = 7'd10; clr_en = 1; clr_idx = 7'd10; step(); idle();
    look(0, 10, 0, 0);
    check(lk_ready[0], 1'b0, "R6", "clear wins same index");
    idle(); set_en = 1; set_idx = 7'd12; clr_en = 1; clr_idx = 7'd13;
    look(0, 12, 0, 0); look(1, 13, 0, 0);
    check(lk_ready[0], 1'b1, "R7", "old value port0");
    check(lk_ready[1], 1'b1, "R7", "old value port1");
    step(); idle();
    look(0, 12, 0, 0); look(1, 13, 0, 0);
    check(lk_ready[0], 1'b1, "R11", "port0 own index");
    check(lk_ready[1], 1'b0, "R11", "port1 own index");
    idle(); set_en = 1; set_idx = 7'd10; step(); idle();
    set_en = 1; set_idx = 7'd13; step(); idle();
  endtask

  task automatic t_random();
    int si, ci, a, b; bit sp, cp, se, ce;
    for (int n = 0; n < 400; n++) begin
      idle();
      se = 1'($urandom); ce = 1'($urandom); sp = ($urandom % 5) == 0; cp = ($urandom % 5) == 0;
      si = $urandom % N; ci = ($urandom % 4 == 0) ? si : $urandom % N;
      a = $urandom % N; b = ($urandom % 3 == 0) ? ci : $urandom % N;
      set_en = se; set_idx = W'(si); set_pinned = sp;
      clr_en = ce; clr_idx = W'(ci); clr_pinned = cp;
      look(0, a, 0, 0); look(1, b, ($urandom % 6) == 0, 0);
      check(lk_ready[0], ref_bits[a], "R11", $sformatf("random port0 idx %0d", a));
      check(lk_ready[1], lk_pinned[1] ? 1'b1 : ref_bits[b], "R11", $sformatf("random port1 idx %0d", b));
      if (se && !sp) ref_bits[si] = 1'b1;
      if (ce && !cp) ref_bits[ci] = 1'b0;
      step();
    end
    idle();
    check(err, 1'b0, "R8", "no error in legal traffic");
  endtask

  task automatic t_oor();
    do_reset();
    clr_en = 1; clr_idx = 7'd5; step(); idle(); ref_bits[5] = 1'b0;
    clr_en = 1; clr_idx = 7'd100; step(); idle();
    check(err, 1'b1, "R8", "err after oor clear");
    look(0, 100, 0, 0);
    check(lk_ready[0], 1'b0, "R8", "oor lookup not ready");
    look(0, 100, 1, 0);
    check(lk_ready[0], 1'b1, "R3", "pinned oor lookup ready");
    idle(); set_en = 1; set_idx = 7'd101; step(); idle();
    for (int i = 0; i < N; i++) begin
      look(0, i, 0, 0);
      check(lk_ready[0], ref_bits[i], "R8", $sformatf("array intact bit %0d", i));
    end
    idle();
  endtask

  task automatic t_zero_fault();
    do_reset();
    clr_en = 1; clr_idx = 7'd5; step(); idle();
    look(0, 5, 0, 1);
    check(lk_ready[0], 1'b0, "R9", "zero-flag lookup of cleared bit");
    check(err, 1'b0, "R9", "err not yet raised");
    step(); idle();
    check(err, 1'b1, "R9", "err raised");
    set_en = 1; set_idx = 7'd5; step(); idle();
    repeat (5) step();
    check(err, 1'b1, "R10", "err sticky");
    do_reset();
    check(err, 1'b0, "R10", "err cleared by reset");
  endtask

  initial begin
    idle(); rst = 1'b1;
    t_reset();
    t_set_clear_bypass();
    t_pinned();
    t_zero_clear();
    t_collision();
    t_random();
    t_oor();
    t_zero_fault();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule